// File: doc/BRIEF.md
# DMA Channel Request Acceptance Core

This block is the control core of a single DMA channel. It decides whether a peripheral request strobe is taken, keeps at most one taken request waiting, and issues a one-cycle start pulse to a bus engine. The bus engine answers each start with a done strobe. The block counts the finished transfers down from a value that software loads. When the last programmed transfer finishes, it sets an end flag and, if enabled, raises an end interrupt.

A request is taken only when all of these hold: the global enable is on, the channel enable is on, and the source selector points at the serial-port request line. The block keeps taking and holding one request even after the count has run out, but it does not act on it while the end flag stays set. When software clears the end flag, that held request starts a transfer straight away. Software that does not want this restart must either drop the channel enable or run one dummy transfer with a count of one, which uses up the held request.

Software reaches the block through three write strobes. The configuration write sets the three enables and the selector. The count write loads the counter. The end-clear write clears the end flag.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all of the following are cleared: the counter, the held request, the end flag, the enables and the selector. In this state `xfer_start` and `end_irq` are 0.
- R2: A request is taken only when `periph_req[SER_SRC]` (bit 2 by default) is 1, the stored selector equals `SER_SRC`, and the global and channel enables are both 1. Strobes on any other line, with any other selector value, or with the global enable at 0 are dropped and are not held for later.
- R3: A request sampled at clock edge k, with no transfer in flight and the end flag clear, makes `xfer_start` high for exactly one cycle, after edge k+1.
- R4: The counter decrements only on a `xfer_done` sampled while a transfer is in flight. A `xfer_done` with no transfer in flight has no effect. No new start is issued while a transfer is in flight.
- R5: The end flag sets on the decrement that takes the counter from 1 to 0. A loaded count of 0 therefore runs 2^CNT_W transfers.
- R6: `end_irq` is high exactly while the end flag is set and the stored interrupt enable is 1.
- R7: While the end flag is set, requests are still taken, but no `xfer_start` is issued.
- R8: Any number of requests that arrive while a transfer is in flight, or while the end flag is set, merge into one held request. They give one start only.
- R9: When the end-clear strobe is sampled at edge k and a request is held, `xfer_start` pulses after edge k+1 with no new request.
- R10: With the channel enable at 0, requests are not taken. Clearing the channel enable also discards a held request.
- R11: Loading a count of 1 and running that transfer uses up the held request. A later end-clear then starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the enables and the selector |
| cfg_glb_en | input | 1 | Global enable value to store |
| cfg_ch_en | input | 1 | Channel enable value to store |
| cfg_irq_en | input | 1 | End interrupt enable value to store |
| cfg_src_sel | input | SEL_W | Request source selector value to store |
| cnt_wr | input | 1 | Write strobe for the transfer counter |
| cnt_wdata | input | CNT_W | Count to load |
| end_clr | input | 1 | Strobe that clears the end flag |
| periph_req | input | NUM_SRC | Peripheral request strobes, one per source |
| xfer_done | input | 1 | Bus engine reports that the current transfer finished |
| xfer_start | output | 1 | One-cycle pulse telling the bus engine to run a transfer |
| end_irq | output | 1 | End-of-transfers interrupt |

## Verification
A lost held request shows up as a missing start pulse two edges after an end-clear. A held request that was not discarded shows up as an extra start, within the same two edges, after a channel disable or after a count-of-one run. A counter that is off by one moves the rise of `end_irq` by one full transfer, and so shows one edge after the wrong done strobe. An end flag that fails to hold starts shows up as a start pulse two edges after a request that arrives once the count is exhausted. Because every start is compared against an expected cycle, a timing slip of a single edge is reported.

// File: rtl/dma_ctrl_pkg.sv
// Package: shared types for the DMA channel control core.
// Assumes: nothing beyond IEEE 1800-2017.
package dma_ctrl_pkg;

    // Software-programmed enable bits of one channel.
    typedef struct packed {
        logic glb_en;
        logic ch_en;
        logic irq_en;
    } dma_en_t;

    // Width of a selector able to name n sources.
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
// Module: dma_cfg_regs
// Holds the enable bits and the request-source selector that software writes.
// Assumes: one write strobe carries all fields. Reset clears every field.
module dma_cfg_regs
    import dma_ctrl_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  dma_en_t          en_wdata,
    input  logic [SEL_W-1:0] sel_wdata,
    output dma_en_t          en_q,
    output logic [SEL_W-1:0] sel_q
);

    // Register the configuration on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else if (wr) begin
            en_q  <= en_wdata;
            sel_q <= sel_wdata;
        end
    end

endmodule

// File: rtl/dma_req_gate.sv
// Module: dma_req_gate
// Qualifies peripheral strobes against the enables and the selector.
// Folds taken requests into one held flag.
// Assumes: only the serial-port source (SER_SRC) may be taken. A start
// consumes the held flag. A request in the same cycle as a start re-arms it.
module dma_req_gate #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2,
    parameter int SER_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic               ch_en,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [NUM_SRC-1:0] periph_req,
    input  logic               start_fire,
    output logic               pend_q
);

    localparam logic [NUM_SRC-1:0] SER_MASK = NUM_SRC'(1) << SER_SRC;

    logic [NUM_SRC-1:0] sel_dec;
    logic               req_hit;

    // One-hot decode of the selector, one line per source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
        assign sel_dec[i] = (src_sel == SEL_W'(i));
    end

    // Request taken: selected line, serial-port source, both enables on.
    always_comb begin
        req_hit = (|(periph_req & sel_dec & SER_MASK)) & glb_en & ch_en;
    end

    // Held request flag: set on a hit, cleared by a start or a channel disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!ch_en) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~start_fire) | req_hit;
        end
    end

endmodule

// File: rtl/dma_xfer_count.sv
// Module: dma_xfer_count
// Transfer counter and end flag.
// Assumes: a software load wins over a decrement in the same cycle. The end
// flag sets on the step from 1 to 0. A set wins over a clear in the same cycle.
module dma_xfer_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             end_clr,
    input  logic             done_fire,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tend_q
);

    logic last_step;

    // A finished transfer that exhausts the count.
    always_comb begin
        last_step = done_fire & (cnt_q == CNT_W'(1));
    end

    // Counter: load on write, otherwise step down per finished transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= cnt_wdata;
        end else if (done_fire) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // End flag: set on the last step, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tend_q <= 1'b0;
        end else if (last_step) begin
            tend_q <= 1'b1;
        end else if (end_clr) begin
            tend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_start_seq.sv
// Module: dma_start_seq
// Issues the start pulse and tracks the one transfer in flight.
// Assumes: the bus engine raises done once per start, on some later cycle.
// A done strobe with nothing in flight is ignored.
module dma_start_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic glb_en,
    input  logic ch_en,
    input  logic pend,
    input  logic tend,
    input  logic xfer_done,
    output logic start_fire,
    output logic done_fire,
    output logic busy_q,
    output logic xfer_start
);

    // Start when a request is held, the channel is idle, enabled and not ended.
    always_comb begin
        start_fire = pend & ~busy_q & ~tend & glb_en & ch_en;
        done_fire  = busy_q & xfer_done;
    end

    // In-flight flag and the registered start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            xfer_start <= 1'b0;
        end else begin
            xfer_start <= start_fire;
            if (start_fire) begin
                busy_q <= 1'b1;
            end else if (done_fire) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_chan_ctrl.sv
// Module: dma_chan_ctrl (top)
// Control core of one DMA channel. Takes requests, counts transfers, holds
// one request past the end of the count, and raises the end interrupt.
// Assumes: synchronous active-low reset. The bus engine answers each
// xfer_start with exactly one xfer_done.
module dma_chan_ctrl
    import dma_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int SER_SRC = 2,
    parameter int CNT_W   = 8,
    localparam int SEL_W  = sel_width(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_glb_en,
    input  logic               cfg_ch_en,
    input  logic               cfg_irq_en,
    input  logic [SEL_W-1:0]   cfg_src_sel,
    input  logic               cnt_wr,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic               end_clr,
    input  logic [NUM_SRC-1:0] periph_req,
    input  logic               xfer_done,
    output logic               xfer_start,
    output logic               end_irq
);

    dma_en_t          en_wdata;
    dma_en_t          en_q;
    logic [SEL_W-1:0] sel_q;
    logic             glb_en_q;
    logic             ch_en_q;
    logic             pend_q;
    logic             tend_q;
    logic             busy_q;
    logic             start_fire;
    logic             done_fire;
    logic [CNT_W-1:0] cnt_q;

    // Pack the configuration write fields.
    always_comb begin
        en_wdata.glb_en = cfg_glb_en;
        en_wdata.ch_en  = cfg_ch_en;
        en_wdata.irq_en = cfg_irq_en;
        glb_en_q        = en_q.glb_en;
        ch_en_q         = en_q.ch_en;
    end

    dma_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .en_wdata  (en_wdata),
        .sel_wdata (cfg_src_sel),
        .en_q      (en_q),
        .sel_q     (sel_q)
    );

    dma_req_gate #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .SER_SRC(SER_SRC)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .glb_en     (glb_en_q),
        .ch_en      (ch_en_q),
        .src_sel    (sel_q),
        .periph_req (periph_req),
        .start_fire (start_fire),
        .pend_q     (pend_q)
    );

    dma_start_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .glb_en     (glb_en_q),
        .ch_en      (ch_en_q),
        .pend       (pend_q),
        .tend       (tend_q),
        .xfer_done  (xfer_done),
        .start_fire (start_fire),
        .done_fire  (done_fire),
        .busy_q     (busy_q),
        .xfer_start (xfer_start)
    );

    dma_xfer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .end_clr   (end_clr),
        .done_fire (done_fire),
        .cnt_q     (cnt_q),
        .tend_q    (tend_q)
    );

    // End interrupt follows the end flag, gated by its enable.
    always_comb begin
        end_irq = tend_q & en_q.irq_en;
    end

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
// Module: dma_chan_ctrl_chk
// Temporal checks on the channel core, bound into every dma_chan_ctrl.
// Assumes: the signals are connected by the bind below.
module dma_chan_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_start,
    input logic             xfer_done,
    input logic             busy,
    input logic             pend,
    input logic             tend,
    input logic             glb_en,
    input logic             ch_en,
    input logic [CNT_W-1:0] cnt
);

    // R3: a start is a single-cycle pulse.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R4: no start while a transfer is in flight and not finishing.
    a_r4_no_start_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_done) |=> !xfer_start);

    // R5: the finishing transfer at count 1 sets the end flag.
    a_r5_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_done && cnt == CNT_W'(1)) |=> tend);

    // R7: no start is seen while the end flag is set.
    a_r7_hold_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        tend |-> !xfer_start);

    // R9: clearing the end flag with a held request restarts at once.
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tend) && pend && !busy && glb_en && ch_en) |=> xfer_start);

    // R10: a disabled channel holds no request.
    a_r10_drop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> !pend);

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .busy       (busy_q),
    .pend       (pend_q),
    .tend       (tend_q),
    .glb_en     (glb_en_q),
    .ch_en      (ch_en_q),
    .cnt        (cnt_q)
);

// File: tb/dma_chan_ctrl_test.sv
// Scoreboard bench: drivers push expected start cycles, a monitor compares.
module dma_chan_ctrl_test;

    localparam int CLK_P   = 10;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = 2;
    localparam int CNT_W   = 8;
    localparam int SER     = 2;

    typedef struct {
        int    cyc;
        string tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_wr = 1'b0;
    logic               cfg_glb_en = 1'b0;
    logic               cfg_ch_en = 1'b0;
    logic               cfg_irq_en = 1'b0;
    logic [SEL_W-1:0]   cfg_src_sel = '0;
    logic               cnt_wr = 1'b0;
    logic [CNT_W-1:0]   cnt_wdata = '0;
    logic               end_clr = 1'b0;
    logic [NUM_SRC-1:0] periph_req = '0;
    logic               xfer_done = 1'b0;
    logic               xfer_start;
    logic               end_irq;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string quiet_tag = "R1";
    exp_t  sb_q[$];

    dma_chan_ctrl #(.NUM_SRC(NUM_SRC), .SER_SRC(SER), .CNT_W(CNT_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_glb_en  (cfg_glb_en),
        .cfg_ch_en   (cfg_ch_en),
        .cfg_irq_en  (cfg_irq_en),
        .cfg_src_sel (cfg_src_sel),
        .cnt_wr      (cnt_wr),
        .cnt_wdata   (cnt_wdata),
        .end_clr     (end_clr),
        .periph_req  (periph_req),
        .xfer_done   (xfer_done),
        .xfer_start  (xfer_start),
        .end_irq     (end_irq)
    );

    always #(CLK_P / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare starts against the scoreboard in the middle of each cycle.
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
            n_chk++;
            if (xfer_start !== 1'b1) begin
                n_bad++;
                $display("FAIL %s: xfer_start at cycle %0d got %b expected 1",
                         sb_q[0].tag, cyc, xfer_start);
            end
            void'(sb_q.pop_front());
        end else if (xfer_start === 1'b1) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s: xfer_start at cycle %0d got 1 expected 0", quiet_tag, cyc);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(input string tag, input logic got, input logic exp);
        @(negedge clk);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic expect_start(input string tag);
        exp_t e;
        e.cyc = cyc + 2;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic cfg(input logic g, input logic c, input logic i, input logic [SEL_W-1:0] s);
        cfg_glb_en = g; cfg_ch_en = c; cfg_irq_en = i; cfg_src_sel = s; cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic load(input int n);
        cnt_wdata = CNT_W'(n); cnt_wr = 1'b1;
        step();
        cnt_wr = 1'b0;
    endtask

    task automatic req(input int line);
        periph_req[line] = 1'b1;
        step();
        periph_req = '0;
    endtask

    task automatic done();
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
    endtask

    task automatic clr();
        end_clr = 1'b1;
        step();
        end_clr = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_P * 50000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        chk("R1 start in reset", xfer_start, 1'b0);
        chk("R1 irq in reset", end_irq, 1'b0);
        rst_n = 1'b1;
        step();
        quiet_tag = "R1";
        req(SER);
        idle(3);
        chk("R1 irq after reset", end_irq, 1'b0);

        // R3, R4, R8: basic run of three transfers
        quiet_tag = "R3";
        cfg(1, 1, 1, 2'(SER));
        load(3);
        expect_start("R3");
        req(SER);
        idle(1);
        quiet_tag = "R4";
        req(SER);                       // arrives while busy: held
        req(SER);                       // folds into the same held flag (R8)
        idle(1);
        expect_start("R8");
        done();
        idle(3);
        done();                         // count now 1
        idle(1);
        chk("R5 irq before last", end_irq, 1'b0);
        done();                         // idle done must be ignored (R4)
        idle(1);
        chk("R4 idle done ignored", end_irq, 1'b0);
        expect_start("R4");
        req(SER);
        idle(2);
        done();
        chk("R5 end flag on last", end_irq, 1'b1);

        // R7, R6: requests held while ended
        quiet_tag = "R7";
        req(SER);
        idle(2);
        req(SER);
        idle(2);
        req(SER);
        idle(3);
        cfg(1, 1, 0, 2'(SER));
        chk("R6 irq masked", end_irq, 1'b0);
        cfg(1, 1, 1, 2'(SER));
        chk("R6 irq unmasked", end_irq, 1'b1);

        // R9, R11: restart on clear, then a count-of-one run drains it
        load(1);
        expect_start("R9");
        clr();
        chk("R9 irq cleared", end_irq, 1'b0);
        quiet_tag = "R8";
        idle(6);
        done();
        chk("R5 count of one ends", end_irq, 1'b1);
        quiet_tag = "R11";
        clr();
        idle(8);
        chk("R11 irq after clear", end_irq, 1'b0);

        // R2: wrong line, wrong selector, global off
        quiet_tag = "R2";
        load(2);
        req(1);
        cfg(1, 1, 1, 2'd1);
        req(1);
        req(SER);
        cfg(0, 1, 1, 2'(SER));
        req(SER);
        cfg(1, 1, 1, 2'(SER));
        idle(6);
        expect_start("R2");
        req(SER);
        idle(2);
        done();
        idle(2);
        chk("R2 count not ended", end_irq, 1'b0);

        // R10: channel disable blocks and discards
        quiet_tag = "R10";
        cfg(1, 0, 1, 2'(SER));
        req(SER);
        cfg(1, 1, 1, 2'(SER));
        idle(6);
        expect_start("R10");
        req(SER);
        idle(2);
        done();
        chk("R10 end after last", end_irq, 1'b1);
        quiet_tag = "R10";
        req(SER);                       // held while ended
        cfg(1, 0, 1, 2'(SER));          // discards it
        cfg(1, 1, 1, 2'(SER));
        load(1);
        clr();
        idle(8);
        chk("R10 irq cleared", end_irq, 1'b0);

        // Drain: every expected start must have been seen
        idle(4);
        while (sb_q.size() > 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s: start expected at cycle %0d got none expected 1",
                     sb_q[0].tag, sb_q[0].cyc);
            void'(sb_q.pop_front());
        end
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule